// File: doc/BRIEF.md
# Multi-Step Bus Processor Core

This block is a small datapath with its own controller. It holds four 8-bit general registers, an operand latch `A`, a result latch `G` and an adder/subtractor. All of them sit on one shared 8-bit bus. The bus can also carry an external data word. An operation is requested by putting a 6-bit function word on `func_i` and raising `start_i` while the core is idle. The word is captured into a function register and split into three 2-bit fields: the operation, a destination/first-operand register select (Rx), and a source/second-operand register select (Ry).

A 2-bit step counter, which clears synchronously, sequences the work. Its value is decoded into four one-hot step lines. These are combined with one-hot decodes of the three captured fields to form every bus-source select and register-load enable. Load and move complete in one step after capture. Add and subtract take three steps: capture the first operand into `A`, compute into `G`, then write `G` back to Rx. `done_o` is raised in the last step of every operation, and the counter returns to idle on that same edge. The bus value is brought out on `bus_o`. Any register can therefore be observed without side effects by moving it onto itself.

Top module: `proc_core`

## Requirements
- R1: While `rst_ni` is low and after its release, all four registers, `A`, `G`, the step counter and the function register are zero. In idle `done_o` is 0 and `bus_o` is 0.
- R2: In the idle step with `start_i` low, nothing changes: `done_o` stays 0, `bus_o` stays 0, and no register is written.
- R3: When `start_i` is high in the idle step, `func_i` is captured with operation in bits [5:4], Rx in [3:2] and Ry in [1:0]. Changes on `func_i` or `start_i` while an operation runs have no effect on it.
- R4: Operation 00 (load): in the step after capture, `bus_o` equals `data_i` and `done_o` is 1. Rx takes `data_i` on that edge.
- R5: Operation 01 (move): in the step after capture, `bus_o` equals Ry and `done_o` is 1. Rx takes the value of Ry on that edge. Rx equal to Ry leaves the register unchanged.
- R6: Operation 10 (add): the three steps after capture show `bus_o` = Rx, then Ry, then Rx+Ry modulo 256. `done_o` is high only in the third, and Rx takes the sum on that edge. Rx equal to Ry doubles the register.
- R7: Operation 11 (subtract): as R6, but the third step shows Rx−Ry modulo 256, and Rx takes that value.
- R8: `done_o` is high for exactly one cycle. The next cycle is the idle step again, so a new operation can be captured there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to capture `func_i` and begin; sampled in the idle step only |
| func_i | input | 6 | Function word: operation [5:4], Rx [3:2], Ry [1:0] |
| data_i | input | 8 | External bus source used by load |
| done_o | output | 1 | High in the final step of an operation |
| bus_o | output | 8 | Current value of the shared bus |

## Verification
The checker makes no assumption about `start_i` or `func_i`. The capture gate must hold whatever those two inputs do outside the idle step, so the stimulus deliberately drives random function words during every running operation. The load check compares `bus_o` with `data_i` in the same cycle. It therefore needs nothing from the environment, but the register contents are only meaningful if `data_i` is steady across that step. The stimulus holds `data_i` from the start request until `done_o`. Register contents are observed only through self-moves, so observation never disturbs the state under test.

// File: rtl/proc_pkg.sv
package proc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'b00,
    OP_MOVE = 2'b01,
    OP_ADD  = 2'b10,
    OP_SUB  = 2'b11
  } op_e;
endpackage

// File: rtl/proc_step_ctr.sv
module proc_step_ctr #(
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [SW-1:0] step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     step_o <= '0;
    else if (clr_i)  step_o <= '0;
    else if (en_i)   step_o <= step_o + 1'b1;
  end
endmodule

// File: rtl/proc_onehot_dec.sv
module proc_onehot_dec #(
  parameter int IW = 2,
  localparam int OW = 1 << IW
) (
  input  logic [IW-1:0] sel_i,
  input  logic          en_i,
  output logic [OW-1:0] line_o
);
  for (genvar k = 0; k < OW; k++) begin : g_line
    assign line_o[k] = en_i && (sel_i == IW'(k));
  end
endmodule

// File: rtl/proc_datapath.sv
module proc_datapath #(
  parameter int DW   = 8,
  parameter int NREG = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NREG-1:0] rin_i,
  input  logic [NREG-1:0] rout_i,
  input  logic            ext_out_i,
  input  logic            g_out_i,
  input  logic            a_in_i,
  input  logic            g_in_i,
  input  logic            sub_i,
  input  logic [DW-1:0]   data_i,
  output logic [DW-1:0]   bus_o
);
  logic [DW-1:0] reg_q [NREG];
  logic [DW-1:0] a_q, g_q;
  logic [DW-1:0] reg_mask [NREG+1];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       reg_q[k] <= '0;
      else if (rin_i[k]) reg_q[k] <= bus_o;
    end
    // one-hot AND-OR bus, stands in for tri-state drivers
    assign reg_mask[k+1] = reg_mask[k] | (reg_q[k] & {DW{rout_i[k]}});
  end

  assign reg_mask[0] = (data_i & {DW{ext_out_i}}) | (g_q & {DW{g_out_i}});
  assign bus_o = reg_mask[NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      g_q <= '0;
    end else begin
      if (a_in_i) a_q <= bus_o;
      if (g_in_i) g_q <= sub_i ? a_q - bus_o : a_q + bus_o;
    end
  end
endmodule

// File: rtl/proc_core.sv
module proc_core #(
  parameter int DW    = 8,
  parameter int RSELW = 2,
  localparam int OPW  = 2,
  localparam int NREG = 1 << RSELW,
  localparam int FW   = OPW + 2 * RSELW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [FW-1:0] func_i,
  input  logic [DW-1:0] data_i,
  output logic          done_o,
  output logic [DW-1:0] bus_o
);
  import proc_pkg::*;

  logic [FW-1:0]    fr_q;
  logic [1:0]       step_q;
  logic [3:0]       t_ln;
  logic [3:0]       i_ln;
  logic [NREG-1:0]  x_ln, y_ln;
  logic             fr_in, short_op, long_op;
  logic             rx_src, ry_src;

  assign fr_in = t_ln[0] && start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    fr_q <= '0;
    else if (fr_in) fr_q <= func_i;
  end

  proc_step_ctr #(.SW(2)) u_step (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (done_o),
    .en_i  (fr_in || !t_ln[0]),
    .step_o(step_q)
  );

  proc_onehot_dec #(.IW(2)) u_tdec (
    .sel_i(step_q), .en_i(1'b1), .line_o(t_ln));
  proc_onehot_dec #(.IW(OPW)) u_idec (
    .sel_i(fr_q[FW-1 -: OPW]), .en_i(1'b1), .line_o(i_ln));
  proc_onehot_dec #(.IW(RSELW)) u_xdec (
    .sel_i(fr_q[2*RSELW-1 -: RSELW]), .en_i(1'b1), .line_o(x_ln));
  proc_onehot_dec #(.IW(RSELW)) u_ydec (
    .sel_i(fr_q[RSELW-1:0]), .en_i(1'b1), .line_o(y_ln));

  assign short_op = i_ln[OP_LOAD] || i_ln[OP_MOVE];
  assign long_op  = i_ln[OP_ADD]  || i_ln[OP_SUB];
  assign done_o   = (t_ln[1] && short_op) || (t_ln[3] && long_op);
  assign rx_src   = t_ln[1] && long_op;
  assign ry_src   = (t_ln[1] && i_ln[OP_MOVE]) || (t_ln[2] && long_op);

  proc_datapath #(.DW(DW), .NREG(NREG)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rin_i    (x_ln & {NREG{done_o}}),
    .rout_i   ((x_ln & {NREG{rx_src}}) | (y_ln & {NREG{ry_src}})),
    .ext_out_i(t_ln[1] && i_ln[OP_LOAD]),
    .g_out_i  (t_ln[3]),
    .a_in_i   (rx_src),
    .g_in_i   (t_ln[2] && long_op),
    .sub_i    (i_ln[OP_SUB]),
    .data_i   (data_i),
    .bus_o    (bus_o)
  );
endmodule

// File: rtl/proc_core_chk.sv
module proc_core_chk #(
  parameter int DW = 8,
  parameter int FW = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [DW-1:0] data_i,
  input logic          done_o,
  input logic [DW-1:0] bus_o,
  input logic [1:0]    step_q,
  input logic [FW-1:0] fr_q
);
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == 2'd0 |-> !done_o && bus_o == '0);

  // R3
  func_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q != 2'd0 |=> $stable(fr_q));

  // R4
  load_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == 2'd1 && fr_q[FW-1 -: 2] == 2'b00 |-> done_o && bus_o == data_i);

  // R5
  move_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == 2'd1 && fr_q[FW-1 -: 2] == 2'b01 |-> done_o);

  // R6
  mid_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == 2'd2 |-> !done_o);

  // R7
  last_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q == 2'd3 |-> done_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && step_q == 2'd0);
endmodule

bind proc_core proc_core_chk #(.DW(DW), .FW(FW)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .data_i(data_i),
  .done_o(done_o),
  .bus_o (bus_o),
  .step_q(step_q),
  .fr_q  (fr_q)
);

// File: tb/tb_proc_core.sv
module tb_proc_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] func = '0;
  logic [7:0] data = '0;
  logic       done;
  logic [7:0] bus;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit wd_hit = 0;

  always #2.5 clk = ~clk;

  proc_core dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .func_i(func), .data_i(data), .done_o(done), .bus_o(bus));

  // behavioural reference
  logic [7:0] m_r [4];
  logic [7:0] m_a, m_g;
  logic [1:0] m_op, m_x, m_y;
  int m_step;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) m_r[k] = 8'd0;
      m_a = 0; m_g = 0; m_op = 0; m_x = 0; m_y = 0; m_step = 0;
    end else begin
      case (m_step)
        0: if (start) begin
             m_op = func[5:4]; m_x = func[3:2]; m_y = func[1:0]; m_step = 1;
           end
        1: case (m_op)
             2'd0: begin m_r[m_x] = data; m_step = 0; end
             2'd1: begin m_r[m_x] = m_r[m_y]; m_step = 0; end
             default: begin m_a = m_r[m_x]; m_step = 2; end
           endcase
        2: begin
             m_g = (m_op == 2'd2) ? m_a + m_r[m_y] : m_a - m_r[m_y];
             m_step = 3;
           end
        default: begin m_r[m_x] = m_g; m_step = 0; end
      endcase
    end
  end

  function automatic bit exp_done();
    return (m_step == 1 && m_op < 2) || (m_step == 3 && m_op >= 2);
  endfunction

  function automatic logic [7:0] exp_bus();
    case (m_step)
      0: return 8'd0;
      1: return (m_op == 0) ? data : (m_op == 1) ? m_r[m_y] : m_r[m_x];
      2: return m_r[m_y];
      default: return m_g;
    endcase
  endfunction

  function automatic string req_now();
    if (m_step == 0) return "R2";
    case (m_op)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !wd_hit) begin
      #1;
      chk(done == exp_done(), req_now(), "done", int'(done), int'(exp_done()));
      chk(bus == exp_bus(), req_now(), "bus", int'(bus), int'(exp_bus()));
    end
  end

  // called at a negedge in the idle step; returns bus seen in the step after capture
  task automatic run_op(input logic [1:0] op, input logic [1:0] rx, input logic [1:0] ry,
                        input logic [7:0] d, output logic [7:0] first_bus);
    int steps;
    steps = (op < 2) ? 1 : 3;
    start = 1'b1; func = {op, rx, ry}; data = d;
    @(negedge clk);
    start = 1'b0;
    func = 6'($urandom);   // R3: ignored while running
    #1 first_bus = bus;
    for (int s = 1; s < steps; s++) begin
      @(negedge clk);
      func = 6'($urandom);
      start = 1'($urandom); // R3: start outside idle has no effect
    end
    #1 chk(done === 1'b1, (op < 2) ? "R4" : "R6", "done in last step", int'(done), 1);
    @(negedge clk);
    start = 1'b0;
    #1 chk(done === 1'b0 && bus === 8'd0, "R8", "idle after done", int'(done), 0);
  endtask

  task automatic read_reg(input logic [1:0] k, input logic [7:0] exp, input string req);
    logic [7:0] v;
    run_op(2'd1, k, k, 8'h5A, v);
    chk(v === exp, req, "register readback", int'(v), int'(exp));
  endtask

  initial begin
    logic [7:0] v;
    repeat (2) @(negedge clk);
    chk(done === 1'b0 && bus === 8'd0, "R1", "outputs in reset", int'(bus), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: all registers clear after reset
    for (int k = 0; k < 4; k++) read_reg(2'(k), 8'd0, "R1");
    // R2: idle with random func, start low
    for (int k = 0; k < 3; k++) begin func = 6'($urandom); data = 8'($urandom); @(negedge clk); end
    read_reg(2'd0, 8'd0, "R2");
    // R4: loads
    run_op(2'd0, 2'd0, 2'd3, 8'd200, v); chk(v === 8'd200, "R4", "load bus", int'(v), 200);
    run_op(2'd0, 2'd1, 2'd0, 8'd100, v);
    run_op(2'd0, 2'd2, 2'd1, 8'd5,   v);
    run_op(2'd0, 2'd3, 2'd2, 8'd127, v);
    read_reg(2'd3, 8'd127, "R4");
    // R6: add with wrap 200+100
    run_op(2'd2, 2'd0, 2'd1, 8'hEE, v); chk(v === 8'd200, "R6", "first operand on bus", int'(v), 200);
    read_reg(2'd0, 8'd44, "R6");
    // R7: subtract 100-44, then 5-56 wrapping
    run_op(2'd3, 2'd1, 2'd0, 8'h00, v);
    read_reg(2'd1, 8'd56, "R7");
    run_op(2'd3, 2'd2, 2'd1, 8'h00, v);
    read_reg(2'd2, 8'd205, "R7");
    // R6: self add doubles
    run_op(2'd2, 2'd3, 2'd3, 8'h11, v);
    read_reg(2'd3, 8'd254, "R6");
    // R5: move
    run_op(2'd1, 2'd2, 2'd0, 8'hFF, v); chk(v === 8'd44, "R5", "move source on bus", int'(v), 44);
    read_reg(2'd2, 8'd44, "R5");
    read_reg(2'd0, 8'd44, "R5");
    // mixed random sequence against the model
    for (int n = 0; n < 40; n++) run_op(2'($urandom), 2'($urandom), 2'($urandom), 8'($urandom), v);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    wd_hit = 1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule